// File: doc/BRIEF.md
# Load-use interlock and operand forwarding controller

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it receives the decoded register fields and control bits of the instruction in decode. It keeps its own shadow copy of the register numbers and control bits that move through the execute, memory and write-back pipeline registers. From that copy it decides two things. First, whether the decode instruction has to wait. Second, for the instruction in execute, where each ALU operand should come from.

A load produces its data only at the end of its memory stage. An instruction that reads the loaded register in the very next slot therefore cannot be served by forwarding. The block holds the program counter and the fetch/decode register for one cycle and puts one bubble into execute. The bubble clears the write, load and store controls. After that single stall, the dependent instruction takes the loaded value from the memory/write-back path. Dependencies on a non-load result one slot away use the execute/memory path. Dependencies two slots away use the memory/write-back path. Dependencies three slots away need no forwarding, because the register file writes in the first half of the cycle and is read in the second half. The datapath, ALU, memories and branch logic sit outside this block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted and until the first valid instruction is taken, pc_hold, ifid_hold and idex_bubble are 0, fwd_a and fwd_b are 2'b00, and ex_reg_write, ex_mem_read and ex_mem_write are 0.
- R2: pc_hold, ifid_hold and idex_bubble are equal in every cycle. In a given cycle they are 1 exactly when id_valid is 1 and the instruction now in execute is a load (register write and memory read both set) whose destination is not register 0 and equals id_rs or id_rt.
- R3: In the cycle after idex_bubble is 1, the execute slot holds a bubble. ex_reg_write, ex_mem_read and ex_mem_write are all 0, and fwd_a and fwd_b are 2'b00.
- R4: A load-use dependency causes exactly one stall cycle. The held instruction is accepted in the following cycle and never stalls twice in a row.
- R5: After a load-use stall, the dependent instruction reaches execute and its operand that reads the loaded register gets select 2'b01. The encoding of fwd_a (operand from id_rs) and fwd_b (operand from id_rt) is: 2'b00 register file, 2'b10 execute/memory result, 2'b01 memory/write-back result.
- R6: An operand of the instruction in execute whose register is written by the non-load instruction one slot older (now in memory) gets select 2'b10.
- R7: An operand whose register is written by the instruction two slots older (now in write-back), load or not, gets select 2'b01 when no nearer producer matches.
- R8: An operand whose only producer is three or more slots older gets select 2'b00.
- R9: Register 0 is never forwarded and never causes a stall. An operand reading register 0 always gets 2'b00.
- R10: When both the execute/memory and memory/write-back producers write the operand's register, the execute/memory result wins (2'b10).
- R11: In the sequence load r1; three instructions each reading r1, the stall pushes the instructions two and three slots behind the load far enough back that they read r1 from the register file (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_reg_write | input | 1 | Decode instruction writes a register |
| id_mem_read | input | 1 | Decode instruction is a load |
| id_mem_write | input | 1 | Decode instruction is a store |
| pc_hold | output | 1 | Keep the program counter this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| fwd_a | output | 2 | Source select for the first ALU operand of the execute instruction |
| fwd_b | output | 2 | Source select for the second ALU operand of the execute instruction |
| ex_reg_write | output | 1 | Register-write control of the execute slot |
| ex_mem_read | output | 1 | Load control of the execute slot |
| ex_mem_write | output | 1 | Store control of the execute slot |

## Verification
The bench sweeps producer kind (load or ALU), producer-to-consumer distance one to three, which operand depends, and destination values including register 0. For each point it computes the expected stall count and select code from the distance rule.

- A controller that stalls for ALU results or for a register-0 load loses cycles.
- One that misses the load-use case forwards stale data.
- One that stalls twice shows a second hold cycle.
- One whose bubble keeps the load's controls repeats a memory read.

Directed runs cover the four-instruction load sequence, where a wrong design forwards after the stall instead of using the register file. They also cover a double producer of one register, where a wrong priority picks the older value, and an invalid decode slot whose fields match a load, which must not stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_AW  = 5;
  localparam int NUM_SRC = 2;
  localparam int FWD_W   = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;

  // fields of the instruction held in the execute slot
  typedef struct packed {
    reg_idx_t rs;
    reg_idx_t rt;
    reg_idx_t rd;
    logic     reg_write;
    logic     mem_read;
    logic     mem_write;
  } ex_slot_t;

  // fields kept for the memory slot
  typedef struct packed {
    reg_idx_t rd;
    logic     we;
    logic     ld;
  } mem_slot_t;

  // fields kept for the write-back slot
  typedef struct packed {
    reg_idx_t rd;
    logic     we;
  } wb_slot_t;

  typedef enum logic [FWD_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_ctrl_pipe.sv
module hzd_ctrl_pipe
  import hzd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      id_valid,
  input  ex_slot_t  id_slot,
  input  logic      bubble,
  output ex_slot_t  ex_q,
  output mem_slot_t mem_q,
  output wb_slot_t  wb_q
);
  ex_slot_t  ex_d;
  mem_slot_t mem_d;
  wb_slot_t  wb_d;
  logic      adv_en;

  // the control shadow advances every cycle; a stall only swaps in a bubble
  assign adv_en = 1'b1;

  always_comb begin
    if (bubble || !id_valid) ex_d = '0;
    else                     ex_d = id_slot;
    mem_d.rd = ex_q.rd;
    mem_d.we = ex_q.reg_write;
    mem_d.ld = ex_q.mem_read;
    wb_d.rd  = mem_q.rd;
    wb_d.we  = mem_q.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else if (adv_en) begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
    end
  end

  // R3
  bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!ex_q.reg_write && !ex_q.mem_read && !ex_q.mem_write));
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     id_valid,
  input  reg_idx_t id_rs,
  input  reg_idx_t id_rt,
  input  ex_slot_t ex_slot,
  output logic     stall
);
  logic ex_is_load;
  logic rs_hit;
  logic rt_hit;

  always_comb begin
    ex_is_load = ex_slot.reg_write && ex_slot.mem_read && (ex_slot.rd != '0);
    rs_hit     = (ex_slot.rd == id_rs);
    rt_hit     = (ex_slot.rd == id_rt);
    stall      = id_valid && ex_is_load && (rs_hit || rt_hit);
  end

  // R4
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R9
  r0_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_slot.rd == '0) |-> !stall);
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  reg_idx_t                         src_rs,
  input  reg_idx_t                         src_rt,
  input  mem_slot_t                        mem_slot,
  input  wb_slot_t                         wb_slot,
  output logic [NUM_SRC-1:0][FWD_W-1:0]    sel
);
  reg_idx_t src [NUM_SRC];
  logic     exm_ok;
  logic     wb_ok;

  always_comb begin
    src[0] = src_rs;
    src[1] = src_rt;
    exm_ok = mem_slot.we && !mem_slot.ld && (mem_slot.rd != '0);
    wb_ok  = wb_slot.we && (wb_slot.rd != '0);
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
    fwd_sel_e pick;

    always_comb begin
      if (exm_ok && (mem_slot.rd == src[k]))  pick = FWD_EXM;
      else if (wb_ok && (wb_slot.rd == src[k])) pick = FWD_WB;
      else                                     pick = FWD_RF;
    end

    assign sel[k] = pick;

    // R9
    r0_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src[k] == '0) |-> (sel[k] == FWD_RF));

    // R5
    fwd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel[k]));

    // R2
    load_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_slot.we && mem_slot.ld && (mem_slot.rd != '0)) |-> (mem_slot.rd != src[k]));
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_reg_write,
  input  logic              id_mem_read,
  input  logic              id_mem_write,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic [FWD_W-1:0]  fwd_a,
  output logic [FWD_W-1:0]  fwd_b,
  output logic              ex_reg_write,
  output logic              ex_mem_read,
  output logic              ex_mem_write
);
  logic      rst_meta_n;
  logic      rst_sync_n;
  ex_slot_t  id_slot;
  ex_slot_t  ex_q;
  mem_slot_t mem_q;
  wb_slot_t  wb_q;
  logic      stall;
  logic [NUM_SRC-1:0][FWD_W-1:0] sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    id_slot.rs        = id_rs;
    id_slot.rt        = id_rt;
    id_slot.rd        = id_rd;
    id_slot.reg_write = id_reg_write;
    id_slot.mem_read  = id_mem_read;
    id_slot.mem_write = id_mem_write;
  end

  hzd_load_use u_ldu (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .id_valid (id_valid),
    .id_rs    (id_rs),
    .id_rt    (id_rt),
    .ex_slot  (ex_q),
    .stall    (stall)
  );

  hzd_ctrl_pipe u_pipe (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .id_valid (id_valid),
    .id_slot  (id_slot),
    .bubble   (stall),
    .ex_q     (ex_q),
    .mem_q    (mem_q),
    .wb_q     (wb_q)
  );

  hzd_fwd_sel u_fwd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_rs   (ex_q.rs),
    .src_rt   (ex_q.rt),
    .mem_slot (mem_q),
    .wb_slot  (wb_q),
    .sel      (sel)
  );

  assign pc_hold      = stall;
  assign ifid_hold    = stall;
  assign idex_bubble  = stall;
  assign fwd_a        = sel[0];
  assign fwd_b        = sel[1];
  assign ex_reg_write = ex_q.reg_write;
  assign ex_mem_read  = ex_q.mem_read;
  assign ex_mem_write = ex_q.mem_write;

  // R3
  bubble_fwd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idex_bubble |=> (fwd_a == 2'b00 && fwd_b == 2'b00));
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid;
  logic [4:0] id_rs, id_rt, id_rd;
  logic       id_reg_write, id_mem_read, id_mem_write;
  logic       pc_hold, ifid_hold, idex_bubble;
  logic [1:0] fwd_a, fwd_b;
  logic       ex_reg_write, ex_mem_read, ex_mem_write;

  int  nvec = 0;
  int  nbad = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_ctrl uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
    .id_reg_write(id_reg_write), .id_mem_read(id_mem_read), .id_mem_write(id_mem_write),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read), .ex_mem_write(ex_mem_write)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one decode instruction at the falling edge, sample 1 time unit later
  task automatic step(input logic v, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [4:0] rd, input logic we, input logic ld);
    @(negedge clk);
    id_valid = v; id_rs = rs; id_rt = rt; id_rd = rd;
    id_reg_write = we; id_mem_read = ld; id_mem_write = 1'b0;
    #1;
    chk("R2 hold lines agree", {6'd0, ifid_hold, idex_bubble}, {6'd0, pc_hold, pc_hold});
  endtask

  task automatic filler();
    step(1'b1, 5'd20, 5'd21, 5'd22, 1'b1, 1'b0);
  endtask

  task automatic run_case(input logic ld, input int d, input int op, input logic [4:0] p);
    int         n;
    logic [1:0] ef;
    logic [4:0] rs_d, rt_d;
    string      tag_s, tag_f;
    repeat (4) filler();
    step(1'b1, 5'd26, 5'd27, p, 1'b1, ld);
    for (int i = 1; i < d; i++) filler();
    rs_d = (op == 0) ? p : 5'd25;
    rt_d = (op == 0) ? 5'd25 : p;
    n = 0;
    step(1'b1, rs_d, rt_d, 5'd23, 1'b1, 1'b0);
    while (pc_hold && n < 3) begin
      n++;
      step(1'b1, rs_d, rt_d, 5'd23, 1'b1, 1'b0);
      chk("R3 bubble slot", {3'd0, ex_reg_write, ex_mem_read, ex_mem_write, 2'd0},
          8'd0);
      chk("R3 bubble selects", {4'd0, fwd_a, fwd_b}, 8'd0);
    end
    tag_s = (p == 0) ? "R9 stall count" : (ld && d == 1) ? "R4 stall count" : "R2 stall count";
    chk(tag_s, n[7:0], (ld && d == 1 && p != 0) ? 8'd1 : 8'd0);
    filler();
    if (p == 0)      ef = 2'b00;
    else if (d == 1) ef = ld ? 2'b01 : 2'b10;
    else if (d == 2) ef = 2'b01;
    else             ef = 2'b00;
    if (p == 0)      tag_f = "R9 select";
    else if (d == 1) tag_f = ld ? "R5 select" : "R6 select";
    else if (d == 2) tag_f = "R7 select";
    else             tag_f = "R8 select";
    if (op == 0) begin
      chk(tag_f, {6'd0, fwd_a}, {6'd0, ef});
      chk("R8 other operand", {6'd0, fwd_b}, 8'd0);
    end else begin
      chk(tag_f, {6'd0, fwd_b}, {6'd0, ef});
      chk("R8 other operand", {6'd0, fwd_a}, 8'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int stalls;
    rst_n = 1'b0;
    id_valid = 1'b0; id_rs = '0; id_rt = '0; id_rd = '0;
    id_reg_write = 1'b0; id_mem_read = 1'b0; id_mem_write = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 holds in reset", {5'd0, pc_hold, ifid_hold, idex_bubble}, 8'd0);
    chk("R1 selects in reset", {4'd0, fwd_a, fwd_b}, 8'd0);
    chk("R1 ex controls in reset", {5'd0, ex_reg_write, ex_mem_read, ex_mem_write}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
    chk("R1 idle after release", {3'd0, pc_hold, fwd_a, fwd_b}, 8'd0);

    // sweep: producer kind x distance x operand x destination
    for (int ld = 0; ld < 2; ld++)
      for (int d = 1; d <= 3; d++)
        for (int op = 0; op < 2; op++)
          for (int pi = 0; pi < 4; pi++)
            run_case(ld[0], d, op, (pi == 0) ? 5'd0 : (pi == 1) ? 5'd1 : (pi == 2) ? 5'd7 : 5'd31);

    // R11: load r1 followed by three readers of r1
    repeat (4) filler();
    stalls = 0;
    step(1'b1, 5'd1, 5'd0, 5'd1, 1'b1, 1'b1);
    if (pc_hold) stalls++;
    step(1'b1, 5'd1, 5'd5, 5'd4, 1'b1, 1'b0);
    if (pc_hold) stalls++;
    chk("R2 load-use detected", {7'd0, pc_hold}, 8'd1);
    step(1'b1, 5'd1, 5'd5, 5'd4, 1'b1, 1'b0);
    if (pc_hold) stalls++;
    chk("R3 bubble controls", {5'd0, ex_reg_write, ex_mem_read, ex_mem_write}, 8'd0);
    step(1'b1, 5'd1, 5'd7, 5'd6, 1'b1, 1'b0);
    if (pc_hold) stalls++;
    chk("R5 first reader from write-back", {4'd0, fwd_a, fwd_b}, {4'd0, 2'b01, 2'b00});
    step(1'b1, 5'd1, 5'd9, 5'd8, 1'b1, 1'b0);
    if (pc_hold) stalls++;
    chk("R11 second reader from register file", {4'd0, fwd_a, fwd_b}, 8'd0);
    filler();
    if (pc_hold) stalls++;
    chk("R11 third reader from register file", {4'd0, fwd_a, fwd_b}, 8'd0);
    chk("R4 one stall in sequence", stalls[7:0], 8'd1);

    // R10: two producers of r3 back to back
    repeat (4) filler();
    step(1'b1, 5'd26, 5'd27, 5'd3, 1'b1, 1'b0);
    step(1'b1, 5'd26, 5'd27, 5'd3, 1'b1, 1'b0);
    step(1'b1, 5'd25, 5'd3, 5'd23, 1'b1, 1'b0);
    filler();
    chk("R10 nearer producer wins", {4'd0, fwd_a, fwd_b}, {4'd0, 2'b00, 2'b10});

    // R2: invalid decode slot matching a load does not stall
    repeat (4) filler();
    step(1'b1, 5'd26, 5'd27, 5'd5, 1'b1, 1'b1);
    step(1'b0, 5'd5, 5'd5, 5'd6, 1'b1, 1'b0);
    chk("R2 invalid slot no stall", {7'd0, pc_hold}, 8'd0);
    step(1'b1, 5'd5, 5'd20, 5'd6, 1'b1, 1'b0);
    chk("R2 invalid slot leaves no execute controls", {7'd0, pc_hold}, 8'd0);
    filler();
    chk("R7 load two slots back", {4'd0, fwd_a, fwd_b}, {4'd0, 2'b01, 2'b00});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule